// File: doc/BRIEF.md
# Indexed Register Access Window

This block is a compact I/O-mapped pointer/window pair. A host selects one per-port link register by writing a pointer word. It then reads or writes that register through a second location that stores nothing itself. Each access to the window becomes exactly one single-cycle access on a simple downstream register port. The port carries a port number, a register number, read and write strobes, write data and returned read data. The link status, control and error registers live behind that port, outside the block.

The host sees a 16-byte offset space. The pointer word sits at byte offset 00h and the window at 04h. Every other offset reads as zero and ignores writes, and this includes offsets that are not a multiple of four. The pointer has two 8-bit fields with sparse legal codes. When either field holds a code outside its legal set, window reads return zero, window writes are dropped, and nothing reaches the downstream port.

Every host read is answered with a one-cycle valid pulse exactly two cycles after the read strobe. This holds whatever the offset, so the host can issue reads back to back.

Top module: `regwin_top`

## Requirements
- R1: After reset the pointer word reads 00000000h, and no downstream strobe or read-valid pulse is active.
- R2: A write to offset 00h stores write-data bits 15:0 in the pointer. A read of offset 00h returns those bits, with bits 31:16 always zero.
- R3: A write to the pointer never produces a downstream read or write strobe.
- R4: With a legal pointer, a write to offset 04h produces one `dn_wr` pulse in the next cycle. That pulse carries the host write data, the mapped port and the mapped register. Port code 00h maps to `dn_port` 0 and port code 02h maps to `dn_port` 1 (pointer bits 15:8). Register code 00h maps to `dn_reg` 0 (status), 01h to 1 (control) and 02h to 2 (error) (pointer bits 7:0).
- R5: With a legal pointer, a read of offset 04h produces one `dn_rd` pulse in the next cycle, using the same mapping as R4. The host response carries the `dn_rdata` value returned one cycle after that pulse.
- R6: If the register code is 03h or above, a window read returns zero, a window write is dropped, and no downstream strobe is issued.
- R7: If the port code is anything other than 00h or 02h, a window read returns zero, a window write is dropped, and no downstream strobe is issued.
- R8: Offsets 08h–0Fh and every offset with bits 1:0 not zero read as zero. Writes to them change neither the pointer nor any downstream register.
- R9: Each host read yields exactly one `host_rvalid` pulse, two cycles after the read strobe. Reads in consecutive cycles are each answered in order.
- R10: A pointer write takes effect for a window access issued in the very next cycle.
- R11: The window has no storage of its own. A window read right after reset returns the reset value of the selected downstream register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Byte offset within the 16-byte block |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response pulse |
| dn_port | output | 1 | Downstream port number |
| dn_reg | output | 2 | Downstream register number |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wr | output | 1 | Downstream write strobe |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data, one cycle after dn_rd |

## Verification
The assertions assume that the host never raises `host_rd` and `host_wr` in the same cycle. They also assume that the downstream side presents read data exactly one cycle after `dn_rd`. The stimulus issues at most one strobe per cycle. The downstream registers are modelled as a clocked array that registers its read data on `dn_rd`, which meets that latency by construction. Pointer values, including reserved codes, come straight from the test sequence, so no assertion depends on the pointer being legal.

// File: rtl/regwin_pkg.sv
`timescale 1ns/1ps
package regwin_pkg;

  localparam int unsigned FIELD_W = 8;
  localparam int unsigned PTR_W   = 2 * FIELD_W;

  typedef enum logic [1:0] {
    RS_ZERO = 2'd0,
    RS_IDX  = 2'd1,
    RS_WIN  = 2'd2
  } rsp_src_e;

  // Port codes are even numbers 0, 2, 4 ... below twice the port count.
  function automatic logic port_code_ok(input logic [FIELD_W-1:0] code,
                                        input int unsigned nports);
    return (code[0] == 1'b0) && (32'(code[FIELD_W-1:1]) < nports);
  endfunction

  function automatic logic [FIELD_W-1:0] port_code_slot(input logic [FIELD_W-1:0] code);
    return {1'b0, code[FIELD_W-1:1]};
  endfunction

  // Register codes are dense from zero.
  function automatic logic reg_code_ok(input logic [FIELD_W-1:0] code,
                                       input int unsigned nregs);
    return 32'(code) < nregs;
  endfunction

endpackage

// File: rtl/regwin_index.sv
`timescale 1ns/1ps
module regwin_index
  import regwin_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned NUM_REGS  = 3,
  parameter int unsigned PORT_W    = 1,
  parameter int unsigned REG_W     = 2,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wdata_lo,
  output logic [DATA_W-1:0] idx_val,
  output logic [PORT_W-1:0] port_sel,
  output logic [REG_W-1:0]  reg_sel,
  output logic              sel_ok
);

  logic [PTR_W-1:0]   ptr_q;
  logic [FIELD_W-1:0] port_code;
  logic [FIELD_W-1:0] reg_code;

  always_ff @(posedge clk) begin
    if (!rst_n)     ptr_q <= '0;
    else if (wr_en) ptr_q <= wdata_lo;
  end

  assign port_code = ptr_q[PTR_W-1:FIELD_W];
  assign reg_code  = ptr_q[FIELD_W-1:0];

  assign idx_val  = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
  assign port_sel = PORT_W'(port_code_slot(port_code));
  assign reg_sel  = REG_W'(reg_code);
  assign sel_ok   = port_code_ok(port_code, NUM_PORTS) && reg_code_ok(reg_code, NUM_REGS);

  // R2: a write loads the low half exactly
  p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> idx_val[PTR_W-1:0] == $past(wdata_lo));

  // R2 / R8: without a load the pointer keeps its value
  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(idx_val));

endmodule

// File: rtl/regwin_fwd.sv
`timescale 1ns/1ps
module regwin_fwd #(
  parameter int unsigned PORT_W = 1,
  parameter int unsigned REG_W  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_rd,
  input  logic              win_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PORT_W-1:0] port_sel,
  input  logic [REG_W-1:0]  reg_sel,
  input  logic              sel_ok,
  output logic              dn_rd,
  output logic              dn_wr,
  output logic [PORT_W-1:0] dn_port,
  output logic [REG_W-1:0]  dn_reg,
  output logic [DATA_W-1:0] dn_wdata
);

  logic rd_go;
  logic wr_go;

  assign rd_go = win_rd && sel_ok;
  assign wr_go = win_wr && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_rd    <= 1'b0;
      dn_wr    <= 1'b0;
      dn_port  <= '0;
      dn_reg   <= '0;
      dn_wdata <= '0;
    end else begin
      dn_rd <= rd_go;
      dn_wr <= wr_go;
      if (rd_go || wr_go) begin
        dn_port <= port_sel;
        dn_reg  <= reg_sel;
      end
      if (wr_go) dn_wdata <= wdata;
    end
  end

  // R4: a legal window write becomes one downstream write with the host data
  p_wr_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && sel_ok) |=> (dn_wr && !dn_rd && dn_wdata == $past(wdata)
                            && dn_port == $past(port_sel) && dn_reg == $past(reg_sel)));

  // R5: a legal window read becomes one downstream read
  p_rd_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && sel_ok) |=> (dn_rd && !dn_wr && dn_reg == $past(reg_sel)));

  // R6 and R7: reserved pointer codes keep the downstream port quiet
  p_rsv_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_rd || win_wr) && !sel_ok) |=> (!dn_rd && !dn_wr));

  // R4: strobes never overlap
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_rd && dn_wr));

endmodule

// File: rtl/regwin_resp.sv
`timescale 1ns/1ps
module regwin_resp
  import regwin_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  rsp_src_e          src_in,
  input  logic [DATA_W-1:0] idx_val,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata
);

  logic              s1_vld, s2_vld;
  rsp_src_e          s1_src, s2_src;
  logic [DATA_W-1:0] s1_dat, s2_dat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_src <= RS_ZERO;
      s1_dat <= '0;
      s2_vld <= 1'b0;
      s2_src <= RS_ZERO;
      s2_dat <= '0;
    end else begin
      s1_vld <= rd_req;
      s1_src <= src_in;
      s1_dat <= (src_in == RS_IDX) ? idx_val : '0;
      s2_vld <= s1_vld;
      s2_src <= s1_src;
      s2_dat <= s1_dat;
    end
  end

  assign host_rvalid = s2_vld;
  assign host_rdata  = !s2_vld ? '0 : (s2_src == RS_WIN) ? dn_rdata : s2_dat;

  // R9: every read is answered two cycles later
  p_rvalid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ##2 host_rvalid);

  // R9: no response without a read two cycles earlier
  p_rvalid_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |-> $past(rd_req, 2));

  // R2: a pointer readback never shows the reserved upper half
  p_idx_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && s2_src == RS_IDX) |-> host_rdata[DATA_W-1:PTR_W] == '0);

endmodule

// File: rtl/regwin_top.sv
`timescale 1ns/1ps
module regwin_top
  import regwin_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned NUM_REGS  = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  localparam int unsigned PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [PORT_W-1:0] dn_port,
  output logic [REG_W-1:0]  dn_reg,
  output logic              dn_rd,
  output logic              dn_wr,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic [DATA_W-1:0] dn_rdata
);

  localparam logic [ADDR_W-3:0] SLOT_IDX = '0;
  localparam logic [ADDR_W-3:0] SLOT_WIN = (ADDR_W-2)'(1);

  // Named decode events for the assertions
  logic              aligned, at_idx, at_win, at_rsv;
  logic              idx_wr_ev, win_rd_ev, win_wr_ev;
  logic [DATA_W-1:0] idx_val;
  logic [PORT_W-1:0] port_sel;
  logic [REG_W-1:0]  reg_sel;
  logic              sel_ok;
  rsp_src_e          rsp_src;

  assign aligned   = (host_addr[1:0] == 2'b00);
  assign at_idx    = aligned && (host_addr[ADDR_W-1:2] == SLOT_IDX);
  assign at_win    = aligned && (host_addr[ADDR_W-1:2] == SLOT_WIN);
  assign at_rsv    = !(at_idx || at_win);
  assign idx_wr_ev = host_wr && at_idx;
  assign win_rd_ev = host_rd && at_win;
  assign win_wr_ev = host_wr && at_win;

  always_comb begin
    if (at_idx)                rsp_src = RS_IDX;
    else if (at_win && sel_ok) rsp_src = RS_WIN;
    else                       rsp_src = RS_ZERO;
  end

  regwin_index #(
    .NUM_PORTS(NUM_PORTS), .NUM_REGS(NUM_REGS),
    .PORT_W(PORT_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (idx_wr_ev),
    .wdata_lo (host_wdata[PTR_W-1:0]),
    .idx_val  (idx_val),
    .port_sel (port_sel),
    .reg_sel  (reg_sel),
    .sel_ok   (sel_ok)
  );

  regwin_fwd #(
    .PORT_W(PORT_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_fwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_rd   (win_rd_ev),
    .win_wr   (win_wr_ev),
    .wdata    (host_wdata),
    .port_sel (port_sel),
    .reg_sel  (reg_sel),
    .sel_ok   (sel_ok),
    .dn_rd    (dn_rd),
    .dn_wr    (dn_wr),
    .dn_port  (dn_port),
    .dn_reg   (dn_reg),
    .dn_wdata (dn_wdata)
  );

  regwin_resp #(
    .DATA_W(DATA_W)
  ) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (host_rd),
    .src_in      (rsp_src),
    .idx_val     (idx_val),
    .dn_rdata    (dn_rdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata)
  );

  // Input rule: one strobe per cycle at most
  p_host_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && host_wr));

  // R3: a pointer write stays local
  p_idx_wr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_ev |=> (!dn_rd && !dn_wr));

  // R8: writes to reserved offsets leave the pointer and the downstream port alone
  p_rsv_wr_noeffect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && at_rsv) |=> ($stable(idx_val) && !dn_wr));

  // R8: reads of reserved offsets return zero
  p_rsv_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && at_rsv) |-> ##2 (host_rdata == '0));

endmodule

// File: tb/regwin_top_tb.sv
`timescale 1ns/1ps
module regwin_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [0:0]  dn_port;
  logic [1:0]  dn_reg;
  logic        dn_rd, dn_wr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;

  always #4 clk = ~clk;

  regwin_top u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .dn_port(dn_port), .dn_reg(dn_reg),
    .dn_rd(dn_rd), .dn_wr(dn_wr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  // Downstream register file model (two ports x three registers)
  function automatic logic [31:0] tgt_reset(input int p, input int r);
    return 32'hA500_0000 | (32'(p) << 8) | 32'(r);
  endfunction

  logic [31:0] tregs [2][3];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++)
        for (int r = 0; r < 3; r++) tregs[p][r] <= tgt_reset(p, r);
      dn_rdata <= '0;
    end else begin
      if (dn_wr && dn_reg < 2'd3) tregs[dn_port][dn_reg] <= dn_wdata;
      if (dn_rd && dn_reg < 2'd3) dn_rdata <= tregs[dn_port][dn_reg];
    end
  end

  // Reference model state
  int          n_tests = 0, n_fail = 0;
  logic [15:0] m_ptr;
  logic [31:0] m_regs [2][3];
  // expectations for the cycle now being checked
  logic        e_rd, e_wr, e_rv;
  logic [0:0]  e_port;
  logic [1:0]  e_reg;
  logic [31:0] e_wdat, e_rdat;
  string       e_dtag, e_rtag;
  // response expectation one cycle further out
  logic        p_rv;
  logic [31:0] p_rdat;
  string       p_rtag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  task automatic check_cycle();
    chk(dn_rd == e_rd, e_dtag, "dn_rd", 32'(dn_rd), 32'(e_rd));
    chk(dn_wr == e_wr, e_dtag, "dn_wr", 32'(dn_wr), 32'(e_wr));
    if (e_rd || e_wr) begin
      chk(dn_port == e_port && dn_reg == e_reg, e_dtag, "port/reg",
          {28'd0, 1'b0, dn_port, dn_reg}, {28'd0, 1'b0, e_port, e_reg});
    end
    if (e_wr) chk(dn_wdata == e_wdat, e_dtag, "dn_wdata", dn_wdata, e_wdat);
    chk(host_rvalid == e_rv, e_rtag, "host_rvalid", 32'(host_rvalid), 32'(e_rv));
    if (e_rv) chk(host_rdata == e_rdat, e_rtag, "host_rdata", host_rdata, e_rdat);
  endtask

  // One bus cycle: check outputs due now, predict for this access, drive it
  task automatic step(input logic rd, input logic wr, input logic [3:0] a,
                      input logic [31:0] wd, input string tag);
    logic [7:0] pc, rc;
    bit legal;
    int pi;
    @(negedge clk);
    check_cycle();
    e_rv = p_rv; e_rdat = p_rdat; e_rtag = p_rtag;
    pc = m_ptr[15:8];
    rc = m_ptr[7:0];
    legal = (pc == 8'h00 || pc == 8'h02) && (rc <= 8'h02);
    pi = (pc == 8'h02) ? 1 : 0;
    e_rd = 1'b0; e_wr = 1'b0; e_dtag = tag;
    p_rv = rd; p_rdat = '0; p_rtag = tag;
    if (a == 4'h0) begin
      if (rd) p_rdat = {16'd0, m_ptr};
      if (wr) m_ptr = wd[15:0];
    end else if (a == 4'h4 && legal) begin
      e_port = 1'(pi);
      e_reg  = rc[1:0];
      if (rd) begin e_rd = 1'b1; p_rdat = m_regs[pi][rc[1:0]]; end
      if (wr) begin e_wr = 1'b1; e_wdat = wd; m_regs[pi][rc[1:0]] = wd; end
    end
    host_rd = rd; host_wr = wr; host_addr = a; host_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'h0, 32'h0, "idle");
  endtask

  bit done = 0;

  initial begin
    m_ptr = '0;
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 3; r++) m_regs[p][r] = tgt_reset(p, r);
    e_rd = 0; e_wr = 0; e_rv = 0; p_rv = 0;
    e_port = '0; e_reg = '0; e_wdat = '0; e_rdat = '0; p_rdat = '0;
    e_dtag = "R1"; e_rtag = "R1"; p_rtag = "R1";
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet outputs and zero pointer after reset
    idle(1);
    step(1, 0, 4'h0, 32'h0, "R1");
    // R11: window read straight after reset gives the target's reset value
    step(1, 0, 4'h4, 32'h0, "R11");
    idle(2);
    // R2: upper write bits are dropped on readback
    step(0, 1, 4'h0, 32'hDEAD_0201, "R2");
    step(1, 0, 4'h0, 32'h0, "R2");
    // R4, R5: write and read back port 1 control
    step(0, 1, 4'h4, 32'h1234_5678, "R4");
    step(1, 0, 4'h4, 32'h0, "R5");
    idle(2);
    // R10: pointer write then window read in the very next cycle
    step(0, 1, 4'h0, 32'h0000_0002, "R3");
    step(1, 0, 4'h4, 32'h0, "R10");
    step(0, 1, 4'h0, 32'h0000_0200, "R10");
    step(0, 1, 4'h4, 32'hCAFE_0001, "R10");
    step(1, 0, 4'h4, 32'h0, "R10");
    idle(2);
    // R6: reserved register code
    step(0, 1, 4'h0, 32'h0000_0003, "R6");
    step(0, 1, 4'h4, 32'h5555_AAAA, "R6");
    step(1, 0, 4'h4, 32'h0, "R6");
    step(0, 1, 4'h0, 32'h0000_00FF, "R6");
    step(1, 0, 4'h4, 32'h0, "R6");
    // R7: reserved port codes
    step(0, 1, 4'h0, 32'h0000_0100, "R7");
    step(0, 1, 4'h4, 32'h7777_7777, "R7");
    step(1, 0, 4'h4, 32'h0, "R7");
    step(0, 1, 4'h0, 32'h0000_0401, "R7");
    step(0, 1, 4'h4, 32'h8888_8888, "R7");
    step(1, 0, 4'h4, 32'h0, "R7");
    // R6, R7: nothing reached the real registers
    step(0, 1, 4'h0, 32'h0000_0001, "R7");
    step(1, 0, 4'h4, 32'h0, "R7");
    idle(2);
    // R8: reserved and unaligned offsets
    step(0, 1, 4'h8, 32'hFFFF_FFFF, "R8");
    step(0, 1, 4'hC, 32'h0000_0202, "R8");
    step(0, 1, 4'h1, 32'h0000_0202, "R8");
    step(0, 1, 4'h5, 32'h0BAD_0BAD, "R8");
    step(1, 0, 4'h0, 32'h0, "R8");
    step(1, 0, 4'h8, 32'h0, "R8");
    step(1, 0, 4'hF, 32'h0, "R8");
    step(1, 0, 4'h6, 32'h0, "R8");
    step(1, 0, 4'h4, 32'h0, "R8");
    idle(2);
    // R9: back-to-back reads of mixed offsets
    step(1, 0, 4'h0, 32'h0, "R9");
    step(1, 0, 4'h4, 32'h0, "R9");
    step(1, 0, 4'hC, 32'h0, "R9");
    step(1, 0, 4'h4, 32'h0, "R9");
    idle(2);
    // R4, R5: sweep every legal port/register pair
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 3; r++) begin
        step(0, 1, 4'h0, {16'd0, 8'(2 * p), 8'(r)}, "R4");
        step(0, 1, 4'h4, 32'h6000_0000 + 32'(p * 16 + r), "R4");
        step(1, 0, 4'h4, 32'h0, "R5");
      end
    end
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule